// File: doc/BRIEF.md
# Serial-port I/O pin multiplexer

This block manages the four general-purpose pins of one channel of a multi-channel UART. An 8-bit control register holds a 2-bit mode for each pin. A pin can be an input only, a general-purpose output, or one of two clock outputs. Pin 1 can also carry the channel's active-low request-to-send. The block drives an output enable and an output value for each pad. The pad level comes back in on `pad_in`, and the block reads it in every mode. This lets a pin's own driven value loop back into the input port.

The host writes the control register or the 4-bit output-port register through a single write strobe, with a select bit that picks the register. A read strobe gives an 8-bit input-port value. That value is the live pad levels, placed at bit positions set by the channel's place in a channel pair. Pins 0 and 1 each have a change-of-state detector. Each detector synchronizes the pad and raises a sticky flag when it is enabled. Reading the input port clears both flags. The baud clocks, the counter/timer output, RTS and the RTS enable come in from outside as plain signals.

Top module: `spio_pin_mux`

## Requirements
- R1: A write with `wr_sel`=0 loads `wr_data` into the control register, where bits [2i+1:2i] hold the mode of pin i. A write with `wr_sel`=1 loads `wr_data[3:0]` into the output-port register, where bit i belongs to pin i. Either write takes effect in the cycle after the write edge.
- R2: After reset, every mode is 00, every output-port bit is 0, every `pad_oe` bit is low and both change flags are clear.
- R3: Mode 00 holds the pin's `pad_oe` low and its `pad_out` at 0. The pad level still reaches `rd_data` and the input-function outputs.
- R4: In mode 01, pins 0, 2 and 3 drive their output-port bit. Pin 1 drives `rts_n` only when `mr1_rts_en`=1 and output-port bit 1 is 1. Otherwise pin 1 drives output-port bit 1.
- R5: Mode 10 drives pin 3 with `txc16`, pin 2 with `rxc1`, pin 1 with `rxc16` and pin 0 with `txc1`.
- R6: Mode 11 drives pin 3 with `txc1`, pin 2 with `rxc16`, pin 1 with `rxc1` and pin 0 with `txc16`.
- R7: With `ODD_CH`=1, mode 10 on pin 1 drives `ct_out` in place of `rxc16`. With `ODD_CH`=0, `ct_out` has no effect on any pad.
- R8: `tx_clk_ext` follows pad 3, `rx_clk_ext` follows pad 2 and `cts_n_pad` follows pad 0 in every mode, with no register in the path.
- R9: `rd_data` is the live pad levels with no latch. With `PAIR_SECOND`=0, pads 0 to 3 sit at bits 2, 3, 6 and 7. With `PAIR_SECOND`=1, they sit at bits 0, 1, 4 and 5. The other bits read 0. A driven pad reads back its own driven value.
- R10: When `cos_en[i]` is 1, any edge on pad i (i = 0 or 1) sets `cos_flag[i]` on the third clock edge after the pad changes. This includes edges the block drives itself. An edge seen while `cos_en[i]` is 0 leaves the flag clear.
- R11: A cycle with `rd_en` high clears both flags at the next edge. If a new edge is detected in that same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the output-port register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Input-port read strobe; clears the change flags |
| rd_data | output | 8 | Input-port value, live pad levels |
| mr1_rts_en | input | 1 | RTS enable from the channel mode register |
| rts_n | input | 1 | Active-low request-to-send from the channel |
| txc16 | input | 1 | Transmit clock, 16x |
| txc1 | input | 1 | Transmit clock, 1x |
| rxc16 | input | 1 | Receive clock, 16x |
| rxc1 | input | 1 | Receive clock, 1x |
| ct_out | input | 1 | Counter/timer output |
| cos_en | input | 2 | Change-detector enables for pads 1:0 |
| cos_flag | output | 2 | Sticky change flags for pads 1:0 |
| pad_in | input | 4 | Pad levels as seen at the pins |
| pad_oe | output | 4 | Output driver enables |
| pad_out | output | 4 | Output driver values |
| tx_clk_ext | output | 1 | External transmit clock, taken from pad 3 |
| rx_clk_ext | output | 1 | External receive clock, taken from pad 2 |
| cts_n_pad | output | 1 | Clear-to-send, taken from pad 0 |

## Verification
The mode and output-port registers feed the pad drivers through logic only, with no extra register. A corrupted mode field therefore shows up on `pad_oe` and `pad_out` in the same cycle, and loops straight back into `rd_data`. A fault in the three-way RTS gate is visible only when exactly one of its conditions is missing. The bench therefore clears each condition in turn and sets `rts_n` to the opposite of the output-port bit. A fault in a change detector shows up later: a wrong synchronizer depth or a missed edge moves the flag away from the third clock edge. The bench checks the flag on both sides of that edge.

// File: rtl/spio_pkg.sv
package spio_pkg;

    localparam int SPIO_PINS  = 4;
    localparam int SPIO_COS   = 2;
    localparam int SPIO_DW    = 8;
    localparam int SPIO_MODEW = 2;

    typedef enum logic [SPIO_MODEW-1:0] {
        PM_IN   = 2'b00,
        PM_GPO  = 2'b01,
        PM_CLKA = 2'b10,
        PM_CLKB = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic txc16;
        logic txc1;
        logic rxc16;
        logic rxc1;
        logic ct;
    } clk_src_t;

    typedef struct packed {
        logic [SPIO_DW-1:0]   ctrl;
        logic [SPIO_PINS-1:0] opr;
    } cfg_t;

endpackage

// File: rtl/spio_cfg_regs.sv
module spio_cfg_regs
    import spio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [SPIO_DW-1:0]   wr_data,
    output logic [SPIO_DW-1:0]   ctrl_q,
    output logic [SPIO_PINS-1:0] opr_q
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_sel) cfg_d.opr  = wr_data[SPIO_PINS-1:0];
            else        cfg_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ctrl_q = cfg_q.ctrl;
    assign opr_q  = cfg_q.opr;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !$past(wr_sel)) |-> (ctrl_q == $past(wr_data))); // R1

    AST_OPR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_sel)) |-> (opr_q == $past(wr_data[SPIO_PINS-1:0]))); // R1

endmodule

// File: rtl/spio_pin_drv.sv
module spio_pin_drv
    import spio_pkg::*;
#(
    parameter int PIN    = 0,
    parameter bit ODD_CH = 1'b0
) (
    input  logic [SPIO_MODEW-1:0] mode,
    input  logic                  opr_bit,
    input  logic                  mr1_rts_en,
    input  logic                  rts_n,
    input  clk_src_t              src,
    output logic                  oe,
    output logic                  dout
);

    logic clk_a, clk_b, gpo_val;

    always_comb begin
        clk_a = 1'b0;
        clk_b = 1'b0;
        case (PIN)
            3: begin clk_a = src.txc16; clk_b = src.txc1;  end
            2: begin clk_a = src.rxc1;  clk_b = src.rxc16; end
            1: begin clk_a = ODD_CH ? src.ct : src.rxc16; clk_b = src.rxc1; end
            default: begin clk_a = src.txc1; clk_b = src.txc16; end
        endcase
    end

    always_comb begin
        if (PIN == 1 && mr1_rts_en && opr_bit) gpo_val = rts_n;
        else                                   gpo_val = opr_bit;
    end

    always_comb begin
        oe   = 1'b1;
        dout = 1'b0;
        case (pin_mode_e'(mode))
            PM_IN:   oe   = 1'b0;
            PM_GPO:  dout = gpo_val;
            PM_CLKA: dout = clk_a;
            PM_CLKB: dout = clk_b;
            default: oe   = 1'b0;
        endcase
    end

endmodule

// File: rtl/spio_cos_det.sv
module spio_cos_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    input  logic en,
    input  logic clr,
    output logic flag
);

    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic          prev;
        logic          flag;
    } cos_st_t;

    cos_st_t st_d, st_q;
    logic    edge_w;

    assign edge_w = st_q.sync[SW-1] ^ st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SW-2:0], pad};
        st_d.prev = st_q.sync[SW-1];
        if (clr)          st_d.flag = 1'b0;
        if (edge_w && en) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_COS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(flag)) |-> $past(en)); // R10

    AST_COS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !edge_w) |=> !flag); // R11

endmodule

// File: rtl/spio_pin_mux.sv
module spio_pin_mux
    import spio_pkg::*;
#(
    parameter bit ODD_CH      = 1'b0,
    parameter bit PAIR_SECOND = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [SPIO_DW-1:0]   wr_data,
    input  logic                 rd_en,
    output logic [SPIO_DW-1:0]   rd_data,
    input  logic                 mr1_rts_en,
    input  logic                 rts_n,
    input  logic                 txc16,
    input  logic                 txc1,
    input  logic                 rxc16,
    input  logic                 rxc1,
    input  logic                 ct_out,
    input  logic [SPIO_COS-1:0]  cos_en,
    output logic [SPIO_COS-1:0]  cos_flag,
    input  logic [SPIO_PINS-1:0] pad_in,
    output logic [SPIO_PINS-1:0] pad_oe,
    output logic [SPIO_PINS-1:0] pad_out,
    output logic                 tx_clk_ext,
    output logic                 rx_clk_ext,
    output logic                 cts_n_pad
);

    localparam int RD_BASE = PAIR_SECOND ? 0 : 2;

    logic [SPIO_DW-1:0]   ctrl_q;
    logic [SPIO_PINS-1:0] opr_q;
    clk_src_t             src;

    assign src = '{txc16: txc16, txc1: txc1, rxc16: rxc16, rxc1: rxc1, ct: ct_out};

    spio_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .opr_q   (opr_q)
    );

    for (genvar p = 0; p < SPIO_PINS; p++) begin : g_pin
        spio_pin_drv #(.PIN(p), .ODD_CH(ODD_CH)) u_drv (
            .mode       (ctrl_q[SPIO_MODEW*p +: SPIO_MODEW]),
            .opr_bit    (opr_q[p]),
            .mr1_rts_en (mr1_rts_en),
            .rts_n      (rts_n),
            .src        (src),
            .oe         (pad_oe[p]),
            .dout       (pad_out[p])
        );
    end

    for (genvar c = 0; c < SPIO_COS; c++) begin : g_cos
        spio_cos_det #(.STAGES(SYNC_STAGES)) u_cos (
            .clk   (clk),
            .rst_n (rst_n),
            .pad   (pad_in[c]),
            .en    (cos_en[c]),
            .clr   (rd_en),
            .flag  (cos_flag[c])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < SPIO_PINS; p++) begin
            rd_data[RD_BASE + (p % 2) + 4 * (p / 2)] = pad_in[p];
        end
    end

    assign tx_clk_ext = pad_in[3];
    assign rx_clk_ext = pad_in[2];
    assign cts_n_pad  = pad_in[0];

    AST_RTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[3:2] == PM_GPO) && (pad_out[1] != opr_q[1])) |-> (mr1_rts_en && opr_q[1])); // R4

    AST_IN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !$past(wr_sel) && ($past(wr_data[1:0]) == PM_IN)) |-> !pad_oe[0]); // R3

endmodule

// File: tb/spio_pin_mux_bench.sv
module spio_pin_mux_bench;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [3:0] opr;
        logic       mr1;
        logic [3:0] src;   // {txc16, txc1, rxc16, rxc1}
        logic       ct;
        logic       rtsn;
        logic [3:0] eoe;
        logic [3:0] eout;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{8'h55, 4'b1010, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b1111, 4'b1010},
        '{8'h55, 4'b1010, 1'b1, 4'b0000, 1'b0, 1'b0, 4'b1111, 4'b1000},
        '{8'h55, 4'b1000, 1'b1, 4'b0000, 1'b0, 1'b1, 4'b1111, 4'b1000},
        '{8'h44, 4'b1111, 1'b1, 4'b0000, 1'b0, 1'b0, 4'b1010, 4'b1000},
        '{8'hAA, 4'b0000, 1'b0, 4'b1000, 1'b0, 1'b1, 4'b1111, 4'b1000},
        '{8'hAA, 4'b0000, 1'b0, 4'b0001, 1'b0, 1'b1, 4'b1111, 4'b0100},
        '{8'hAA, 4'b0000, 1'b0, 4'b0010, 1'b0, 1'b1, 4'b1111, 4'b0010},
        '{8'hAA, 4'b0000, 1'b0, 4'b0100, 1'b0, 1'b1, 4'b1111, 4'b0001},
        '{8'hFF, 4'b0000, 1'b0, 4'b0100, 1'b0, 1'b1, 4'b1111, 4'b1000},
        '{8'hFF, 4'b0000, 1'b0, 4'b0010, 1'b0, 1'b1, 4'b1111, 4'b0100},
        '{8'hFF, 4'b0000, 1'b0, 4'b0001, 1'b0, 1'b1, 4'b1111, 4'b0010},
        '{8'hFF, 4'b0000, 1'b0, 4'b1000, 1'b0, 1'b1, 4'b1111, 4'b0001},
        '{8'h00, 4'b1111, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0000, 4'b0000},
        '{8'hE4, 4'b0010, 1'b0, 4'b0110, 1'b0, 1'b0, 4'b1110, 4'b1010},
        '{8'hAA, 4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 4'b1111, 4'b0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic mr1 = 1'b0, rtsn = 1'b1;
    logic txc16 = 1'b0, txc1 = 1'b0, rxc16 = 1'b0, rxc1 = 1'b0, ct = 1'b0;
    logic [1:0] cos_en = '0;
    logic [3:0] ext_a = '0, ext_b = '0;

    logic [3:0] oe_a, out_a, pad_a, oe_b, out_b, pad_b;
    logic [7:0] rd_a, rd_b;
    logic [1:0] flag_a, flag_b;
    logic txe_a, rxe_a, cts_a, txe_b, rxe_b, cts_b;

    assign pad_a = (oe_a & out_a) | (~oe_a & ext_a);
    assign pad_b = (oe_b & out_b) | (~oe_b & ext_b);

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spio_pin_mux u_spio_pin_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_a), .mr1_rts_en(mr1), .rts_n(rtsn),
        .txc16(txc16), .txc1(txc1), .rxc16(rxc16), .rxc1(rxc1), .ct_out(ct),
        .cos_en(cos_en), .cos_flag(flag_a), .pad_in(pad_a), .pad_oe(oe_a),
        .pad_out(out_a), .tx_clk_ext(txe_a), .rx_clk_ext(rxe_a), .cts_n_pad(cts_a)
    );

    spio_pin_mux #(.ODD_CH(1'b1), .PAIR_SECOND(1'b1)) u_spio_pin_mux_odd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_b), .mr1_rts_en(mr1), .rts_n(rtsn),
        .txc16(txc16), .txc1(txc1), .rxc16(rxc16), .rxc1(rxc1), .ct_out(ct),
        .cos_en(cos_en), .cos_flag(flag_b), .pad_in(pad_b), .pad_oe(oe_b),
        .pad_out(out_b), .tx_clk_ext(txe_b), .rx_clk_ext(rxe_b), .cts_n_pad(cts_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] map_first(input logic [3:0] p);
        return {p[3], p[2], 2'b00, p[1], p[0], 2'b00};
    endfunction

    function automatic logic [7:0] map_second(input logic [3:0] p);
        return {2'b00, p[3], p[2], 2'b00, p[1], p[0]};
    endfunction

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2 oe after reset", {28'd0, oe_a}, 32'h0);
        chk("R2 out after reset", {28'd0, out_a}, 32'h0);
        chk("R2 flags after reset", {30'd0, flag_a}, 32'h0);

        // R3/R8/R9: input mode, live read, input functions
        ext_a = 4'b0101; ext_b = 4'b0101;
        #1;
        chk("R9 first-pair map", {24'd0, rd_a}, 32'h44);
        chk("R9 second-pair map", {24'd0, rd_b}, 32'h11);
        chk("R8 tx_clk_ext", {31'd0, txe_a}, 32'd0);
        chk("R8 rx_clk_ext", {31'd0, rxe_a}, 32'd1);
        chk("R8 cts_n_pad", {31'd0, cts_a}, 32'd1);
        ext_a = 4'b1010; ext_b = 4'b1010;
        #1;
        chk("R9 first-pair live", {24'd0, rd_a}, 32'h88);
        chk("R9 second-pair live", {24'd0, rd_b}, 32'h22);
        chk("R8 tx_clk_ext high", {31'd0, txe_a}, 32'd1);
        ext_a = 4'b0000; ext_b = 4'b0000;

        // Table walk: R1, R4, R5, R6, R7 (even), R9 loopback
        for (int v = 0; v < NV; v++) begin
            wr_reg(1'b1, {4'h0, TBL[v].opr});
            wr_reg(1'b0, TBL[v].ctrl);
            mr1 = TBL[v].mr1; rtsn = TBL[v].rtsn; ct = TBL[v].ct;
            {txc16, txc1, rxc16, rxc1} = TBL[v].src;
            #1;
            chk($sformatf("R1/R3 row %0d oe", v), {28'd0, oe_a}, {28'd0, TBL[v].eoe});
            chk($sformatf("R4/R5/R6/R7 row %0d out", v), {28'd0, out_a}, {28'd0, TBL[v].eout});
            chk($sformatf("R9 row %0d loopback", v), {24'd0, rd_a}, {24'd0, map_first(TBL[v].eout)});
        end

        // R7: odd channel pin 1 mode 10 follows ct_out
        wr_reg(1'b0, 8'hAA);
        {txc16, txc1, rxc16, rxc1} = 4'b0010; ct = 1'b0;
        #1;
        chk("R7 odd ignores rxc16", {31'd0, out_b[1]}, 32'd0);
        {txc16, txc1, rxc16, rxc1} = 4'b0000; ct = 1'b1;
        #1;
        chk("R7 odd drives ct_out", {31'd0, out_b[1]}, 32'd1);
        chk("R9 odd loopback", {24'd0, rd_b}, {24'd0, map_second(4'b0010)});
        ct = 1'b0;

        // R10: change detect on own driven value, timed
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h03);
        mr1 = 1'b0;
        cos_en = 2'b11;
        wait_neg(4);
        pulse_rd();
        chk("R11 flags clear before loopback", {30'd0, flag_a}, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h05;
        @(negedge clk);
        wr_en = 1'b0;
        wait_neg(2);
        chk("R10 flag not before third edge", {30'd0, flag_a}, 32'h0);
        @(negedge clk);
        chk("R10 flag on third edge (own drive)", {30'd0, flag_a}, 32'h3);

        // R11: read clears
        pulse_rd();
        chk("R11 read clears flags", {30'd0, flag_a}, 32'h0);

        // R10: disabled detector ignores an edge
        wr_reg(1'b0, 8'h00);
        cos_en = 2'b00;
        pulse_rd();
        ext_a[0] = 1'b1;
        wait_neg(5);
        chk("R10 disabled edge ignored", {30'd0, flag_a}, 32'h0);

        // R11: set wins over a simultaneous read
        cos_en = 2'b01;
        @(negedge clk);
        ext_a[0] = 1'b0;
        wait_neg(2);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R11 set wins over clear", {30'd0, flag_a}, 32'h1);
        pulse_rd();
        chk("R11 cleared afterwards", {30'd0, flag_a}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule